// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single memory-mapped countdown timer channel. Software programs a start count and a control word through a small synchronous register bus. Once enabled, the counter decrements by one on each pulse of the selected tick enable. Two tick enables are available, a slow one and a fast one, and both are generated outside the block.

When the count is at zero and a selected tick arrives, the channel underflows. In periodic mode it then restarts from the programmed load value. In free-running mode it wraps to all ones. Every underflow sets a level interrupt, which stays high until software writes to the clear address.

The counter width is a parameter. It is meant to be 16 or 32 bits, so one design serves both the short and the long channels of a timer bank.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset is asserted (rst_ni low), the load value, the count, the control bits and irq_o are all zero.
- R2: The registers decode on the full 4-bit address: 0x0 is load (read/write), 0x4 is current count (read-only), 0x8 is control (read/write) and 0xC is interrupt clear. The clear address always reads zero. The control register reads back only bits 7, 6 and 3; all other control bits read as zero.
- R3: A write to the load register sets the load value and the current count on the same clock edge. If a selected tick arrives in that same cycle, it is ignored.
- R4: With control bit 7 set, the count drops by one on each selected tick. With bit 7 clear, the count holds.
- R5: Control bit 3 selects the tick source: 0 selects tick_slow_i and 1 selects tick_fast_i. Pulses on the input that is not selected have no effect.
- R6: A selected tick while the count is zero is an underflow. irq_o goes high on the following clock edge and stays high until it is cleared.
- R7: With control bit 6 set (periodic), an underflow reloads the count from the load register.
- R8: With control bit 6 clear (free-running), an underflow wraps the count to all ones.
- R9: A write of any data to address 0xC drops irq_o. If an underflow happens in the same cycle as the clear write, irq_o stays high.
- R10: CNT_W sets the counter width (16 or 32). Reads of the count are zero-extended to 32 bits, and a wrap produces 0xFFFF or 0xFFFFFFFF to match the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational from addr_i) |
| tick_slow_i | input | 1 | Slow tick enable |
| tick_fast_i | input | 1 | Fast tick enable |
| irq_o | output | 1 | Pending underflow interrupt (level) |

## Verification
A wrong count shows on the value register one cycle after the tick that produced it. Each underflow step is followed by a reload or a wrap, so a bad count value propagates and stays visible. A wrong tick selection or enable shows as a count that moves when it should hold, or holds when it should move, on the very next read. A fault in the interrupt flag appears on irq_o one edge after the underflow or the clear write that should have changed it. The tests sweep several load values in both modes, so a reload error is seen within one period of the programmed count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] OFF_LOAD = 4'h0;
  localparam logic [3:0] OFF_VAL  = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h8;
  localparam logic [3:0] OFF_CLR  = 4'hC;

  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              load_wr_o,
  output logic [CNT_W-1:0]  load_new_o,
  output logic              clr_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign load_wr_o  = we_i && (addr_i == OFF_LOAD);
  assign clr_wr_o   = we_i && (addr_i == OFF_CLR);
  assign load_new_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (load_wr_o) load_o <= load_new_o;
      if (we_i && (addr_i == OFF_CTRL))
        ctrl_o <= '{en: wdata_i[BIT_EN], periodic: wdata_i[BIT_PER], fast: wdata_i[BIT_FAST]};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_LOAD: rdata_o = DATA_W'(load_o);
      OFF_VAL:  rdata_o = DATA_W'(cnt_i);
      OFF_CTRL: begin
        rdata_o[BIT_EN]   = ctrl_o.en;
        rdata_o[BIT_PER]  = ctrl_o.periodic;
        rdata_o[BIT_FAST] = ctrl_o.fast;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_new_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);
  logic tick, step;
  logic [CNT_W-1:0] cnt_d;

  assign tick    = ctrl_i.fast ? tick_fast_i : tick_slow_i;
  assign step    = ctrl_i.en && tick && !load_wr_i;   // load write wins
  assign uflow_o = step && (cnt_o == '0);

  always_comb begin
    cnt_d = cnt_o;
    if (load_wr_i)    cnt_d = load_new_i;
    else if (uflow_o) cnt_d = ctrl_i.periodic ? load_i : '1;
    else if (step)    cnt_d = cnt_o - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uflow_i,
  input  logic clr_wr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_o <= 1'b0;
    else if (uflow_i)  irq_o <= 1'b1;   // set beats clear
    else if (clr_wr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, load_new, cnt_q;
  logic             load_wr, clr_wr, uflow;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .cnt_i(cnt_q), .ctrl_o(ctrl_q), .load_o(load_q),
    .load_wr_o(load_wr), .load_new_o(load_new),
    .clr_wr_o(clr_wr), .rdata_o
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .ctrl_i(ctrl_q), .tick_slow_i, .tick_fast_i,
    .load_wr_i(load_wr), .load_new_i(load_new), .load_i(load_q),
    .cnt_o(cnt_q), .uflow_o(uflow)
  );

  tmr_irq i_irq (
    .clk_i, .rst_ni, .uflow_i(uflow), .clr_wr_i(clr_wr), .irq_o
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             periodic_i,
  input logic             load_wr_i,
  input logic             clr_wr_i,
  input logic             uflow_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] load_i,
  input logic             irq_o
);
  // R6
  underflow_sets_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_i |=> irq_o);
  // R6
  irq_level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr_i) |=> irq_o);
  // R9
  clear_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !uflow_i) |=> !irq_o);
  // R4
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_wr_i) |=> $stable(cnt_i));
  // R7
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uflow_i && periodic_i) |=> (cnt_i == $past(load_i)));
  // R8
  free_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uflow_i && !periodic_i) |=> (cnt_i == '1));
endmodule

bind reload_timer_chan tmr_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni,
  .en_i(ctrl_q.en), .periodic_i(ctrl_q.periodic),
  .load_wr_i(load_wr), .clr_wr_i(clr_wr), .uflow_i(uflow),
  .cnt_i(cnt_q), .load_i(load_q), .irq_o
);

// File: tb/test_reload_timer_chan.sv
module test_reload_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        tslow = 1'b0, tfast = 1'b0;
  logic [31:0] rdata, rdata32;
  logic        irq, irq32;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reload_timer_chan #(.CNT_W(16)) i_reload_timer_chan (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_slow_i(tslow), .tick_fast_i(tfast), .irq_o(irq));

  reload_timer_chan #(.CNT_W(32)) i_reload_timer_chan_w32 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata32), .tick_slow_i(tslow), .tick_fast_i(tfast), .irq_o(irq32));

  localparam logic [3:0] A_LOAD = 4'h0, A_VAL = 4'h4, A_CTRL = 4'h8, A_CLR = 4'hC;
  localparam logic [31:0] C_EN = 32'h80, C_PER = 32'h40, C_FAST = 32'h08;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] d32);
    addr = a; #1; d = rdata; d32 = rdata32;
  endtask

  task automatic pulse(input bit fast);
    @(negedge clk); if (fast) tfast = 1'b1; else tslow = 1'b1;
    @(negedge clk); tfast = 1'b0; tslow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v32;
    int exp_v;
    bit exp_irq;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_VAL, v, v32);  check("R1 value", v, 0);
    rd(A_LOAD, v, v32); check("R1 load", v, 0);
    rd(A_CTRL, v, v32); check("R1 ctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register map and readback
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v, v32); check("R2 ctrl mask", v, 32'hC8);
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'h1234_ABCD);
    rd(A_LOAD, v, v32); check("R2 load 16b", v, 32'h0000_ABCD);
    check("R10 load 32b", v32, 32'h1234_ABCD);
    rd(A_CLR, v, v32); check("R2 clear reads zero", v, 0);
    // R3 load write also sets value
    rd(A_VAL, v, v32); check("R3 value follows load", v, 32'hABCD);

    // R7/R6/R4 sweep in periodic mode over several load values, fast tick
    for (int l = 0; l < 6; l++) begin
      wr(A_CTRL, 0);
      wr(A_LOAD, l);
      wr(A_CLR, 32'h5A);
      rd(A_VAL, v, v32); check("R3 load value", v, l);
      check("R9 cleared", {31'b0, irq}, 0);
      wr(A_CTRL, C_EN | C_PER | C_FAST);
      exp_v = l; exp_irq = 0;
      for (int k = 0; k < 2 * l + 3; k++) begin
        pulse(1);
        if (exp_v == 0) begin exp_v = l; exp_irq = 1; end
        else exp_v = exp_v - 1;
        rd(A_VAL, v, v32); check("R7 periodic count", v, exp_v);
        check("R6 irq level", {31'b0, irq}, {31'b0, exp_irq});
      end
      // R5 unselected slow tick ignored
      pulse(0);
      rd(A_VAL, v, v32); check("R5 slow ignored", v, exp_v);
    end

    // R5 slow source selected
    wr(A_CTRL, 0); wr(A_LOAD, 10); wr(A_CTRL, C_EN | C_PER);
    pulse(1); rd(A_VAL, v, v32); check("R5 fast ignored", v, 10);
    pulse(0); rd(A_VAL, v, v32); check("R5 slow counts", v, 9);
    pulse(0); rd(A_VAL, v, v32); check("R5 slow counts", v, 8);

    // R4 disabled hold
    wr(A_CTRL, C_PER);
    pulse(0); pulse(1); rd(A_VAL, v, v32); check("R4 hold when disabled", v, 8);

    // R8 / R10 free-running wrap at both widths
    wr(A_CLR, 0);
    wr(A_LOAD, 0); wr(A_CTRL, C_EN | C_FAST);
    pulse(1);
    rd(A_VAL, v, v32);
    check("R8 wrap 16b", v, 32'h0000_FFFF);
    check("R10 wrap 32b", v32, 32'hFFFF_FFFF);
    check("R6 irq after wrap", {31'b0, irq}, 1);
    pulse(1); rd(A_VAL, v, v32); check("R8 count after wrap", v, 32'hFFFE);
    // R6 irq stays as level with no clear
    repeat (4) @(negedge clk);
    check("R6 irq held", {31'b0, irq}, 1);

    // R3 load write beats a tick in the same cycle
    @(negedge clk); addr = A_LOAD; wdata = 9; we = 1'b1; tfast = 1'b1;
    @(negedge clk); we = 1'b0; tfast = 1'b0;
    rd(A_VAL, v, v32); check("R3 load wins over tick", v, 9);

    // R9 clear and underflow in the same cycle: irq stays
    wr(A_CTRL, 0); wr(A_LOAD, 0); wr(A_CLR, 0);
    check("R9 clear drops irq", {31'b0, irq}, 0);
    wr(A_CTRL, C_EN | C_PER | C_FAST);
    @(negedge clk); addr = A_CLR; wdata = 32'hFFFF_FFFF; we = 1'b1; tfast = 1'b1;
    @(negedge clk); we = 1'b0; tfast = 1'b0;
    check("R9 underflow beats clear", {31'b0, irq}, 1);
    wr(A_CLR, 32'h1);
    check("R9 clear any data", {31'b0, irq}, 0);

    // R4 zero control stops the counter
    wr(A_LOAD, 3); wr(A_CTRL, 0);
    pulse(1); rd(A_VAL, v, v32); check("R4 stopped", v, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule